// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads a two-level page table that sits in main memory. A requester supplies the logical address, the base of the root table and a flag that marks the access as a write. The walker reads the outer-level entry, uses that entry to find the inner table, and then reads the inner-level entry that holds the physical frame. It returns the frame number, the physical address and the permission bits of that entry, or a fault code.

The memory side is a plain request/response port. A one-cycle request pulse carries a word address. Memory answers later with a one-cycle read-valid and the data word. The walker handles one translation at a time. It has no translation cache, and it does not perform the final data access.

Top module: `pt_walker`

## Requirements
- R1: The logical address divides into an outer index (bits 31:22), an inner index (bits 21:12) and a page offset (bits 11:0). The first read goes to `{root[31:12],12'h000} + 4*outer_index`, so bits 11:0 of the root input are ignored. The second read goes to `{entry1[31:12],12'h000} + 4*inner_index`.
- R2: A successful walk returns `resp_frame_o` equal to bits 31:12 of the inner entry. `resp_paddr_o` is that frame concatenated with the unchanged page offset, and `resp_fault_o` is 0.
- R3: An entry marks the valid flag in bit 0, the readable flag in bit 1 and the writable flag in bit 2. On success, `resp_perm_o` equals bits 2:0 of the inner entry. Only the valid flag and, for writes, the writable flag affect the outcome.
- R4: An outer entry with bit 0 clear ends the walk after one memory read with page fault code 1. `resp_frame_o`, `resp_paddr_o` and `resp_perm_o` are then zero.
- R5: An inner entry with bit 0 clear gives page fault code 1 after two reads. Frame, physical address and permissions are then zero.
- R6: A write to a valid inner entry whose bit 2 is clear gives protection fault code 2. The frame and physical address are then zero, and `resp_perm_o` shows the entry's bits 2:0. A read of the same page succeeds.
- R7: `req_ready_o` is low from the cycle after a request is accepted until the walk ends. Requests presented during that time are ignored.
- R8: If memory answers L cycles after each request pulse, `resp_valid_o` is high for exactly one cycle. That cycle is 3+2L cycles after the accepting edge for a two-read walk, and 2+L cycles after it for an outer-level fault. The walker is ready again in the next cycle.
- R9: `mem_req_o` is a one-cycle pulse. A walk issues exactly one pulse per table level it reads, and only one read is outstanding at a time.
- R10: While `rst_ni` is low, and after it is released, the walker is ready, `resp_valid_o` is low and `mem_req_o` is low. Asserting reset in the middle of a walk abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr_i | input | 32 | Logical address |
| req_root_i | input | 32 | Root table base (bits 11:0 ignored) |
| req_write_i | input | 1 | Access is a write |
| mem_req_o | output | 1 | Table read request pulse |
| mem_addr_o | output | 32 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| resp_valid_o | output | 1 | Result valid pulse |
| resp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| resp_frame_o | output | 20 | Physical frame number |
| resp_paddr_o | output | 32 | Physical address |
| resp_perm_o | output | 3 | Entry bits {writable, readable, valid} |

## Verification
With memory latency L, the response is due exactly 3+2L cycles after the accepting edge for a full walk, and 2+L cycles after it for an outer-level fault. Memory requests follow the same ladder: the first one comes in the cycle after acceptance, and the second comes one cycle after the first read data arrives. The bench samples on falling edges and counts cycles from acceptance until it sees the response. It compares that count with the formula for L = 1, 2 and 3. In the cycle after the response it checks that the pulse has ended and that the walker is ready again.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_RESP
  } walk_st_e;

  localparam int PTE_V  = 0;
  localparam int PTE_R  = 1;
  localparam int PTE_W  = 2;
  localparam int PERM_W = 3;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W,
  localparam int PN_W = AW - OFF_W
) (
  input  logic [PN_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  // entries are 4 bytes wide
  assign addr_o = {base_i, {OFF_W{1'b0}}} + (AW'(idx_i) << 2);
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walk_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W,
  localparam int PN_W = AW - OFF_W
) (
  input  logic              level2_i,
  input  logic              write_i,
  input  logic [PN_W-1:0]   pte_pn_i,
  input  logic [PERM_W-1:0] pte_perm_i,
  output fault_e            fault_o,
  output logic [PN_W-1:0]   frame_o,
  output logic [PERM_W-1:0] perm_o
);
  logic valid;
  assign valid = pte_perm_i[PTE_V];

  always_comb begin
    if (!valid)                                   fault_o = FLT_PAGE;
    else if (level2_i && write_i && !pte_perm_i[PTE_W]) fault_o = FLT_PROT;
    else                                          fault_o = FLT_NONE;
  end

  assign frame_o = (fault_o == FLT_NONE) ? pte_pn_i : '0;
  assign perm_o  = (level2_i && valid) ? pte_perm_i : '0;
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W,
  localparam int PN_W = AW - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     vaddr_i,
  input  logic [PN_W-1:0]   root_pn_i,
  input  logic              write_i,
  input  logic              mem_rvalid_i,
  input  logic [PN_W-1:0]   rdata_pn_i,
  input  fault_e            chk_fault_i,
  input  logic [PN_W-1:0]   chk_frame_i,
  input  logic [PERM_W-1:0] chk_perm_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic              level2_o,
  output logic [PN_W-1:0]   base_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              write_o,
  output logic              resp_valid_o,
  output fault_e            resp_fault_o,
  output logic [PN_W-1:0]   resp_frame_o,
  output logic [AW-1:0]     resp_paddr_o,
  output logic [PERM_W-1:0] resp_perm_o
);
  walk_st_e          st_q;
  logic [AW-1:0]     vaddr_q;
  logic [PN_W-1:0]   root_q, next_q, frame_q;
  logic              wr_q;
  fault_e            fault_q;
  logic [PERM_W-1:0] perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      root_q  <= '0;
      next_q  <= '0;
      wr_q    <= 1'b0;
      fault_q <= FLT_NONE;
      frame_q <= '0;
      perm_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= vaddr_i;
          root_q  <= root_pn_i;
          wr_q    <= write_i;
          st_q    <= ST_RD1;
        end
        ST_RD1: st_q <= ST_WT1;
        ST_WT1: if (mem_rvalid_i) begin
          if (chk_fault_i != FLT_NONE) begin
            fault_q <= chk_fault_i;
            frame_q <= chk_frame_i;
            perm_q  <= chk_perm_i;
            st_q    <= ST_RESP;
          end else begin
            next_q <= rdata_pn_i;
            st_q   <= ST_RD2;
          end
        end
        ST_RD2: st_q <= ST_WT2;
        ST_WT2: if (mem_rvalid_i) begin
          fault_q <= chk_fault_i;
          frame_q <= chk_frame_i;
          perm_q  <= chk_perm_i;
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign level2_o     = (st_q == ST_RD2) || (st_q == ST_WT2);
  assign base_o       = level2_o ? next_q : root_q;
  assign idx_o        = level2_o ? vaddr_q[OFF_W +: IDX_W] : vaddr_q[OFF_W+IDX_W +: IDX_W];
  assign write_o      = wr_q;
  assign resp_valid_o = (st_q == ST_RESP);
  assign resp_fault_o = fault_q;
  assign resp_frame_o = frame_q;
  assign resp_perm_o  = perm_q;
  assign resp_paddr_o = (fault_q == FLT_NONE) ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_resp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  p_ready_after_resp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> req_ready_o);
  p_mem_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_prot_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (resp_fault_o == FLT_PROT) |-> wr_q);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W,
  localparam int PN_W = AW - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_vaddr_i,
  input  logic [AW-1:0]     req_root_i,
  input  logic              req_write_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_fault_o,
  output logic [PN_W-1:0]   resp_frame_o,
  output logic [AW-1:0]     resp_paddr_o,
  output logic [PERM_W-1:0] resp_perm_o
);
  logic              level2, write_q;
  logic [PN_W-1:0]   base, chk_frame;
  logic [IDX_W-1:0]  idx;
  logic [PERM_W-1:0] chk_perm;
  fault_e            chk_fault, fault;

  // low bits of root and entries carry no meaning here
  logic unused_bits;
  assign unused_bits = ^{req_root_i[OFF_W-1:0], mem_rdata_i[OFF_W-1:PERM_W]};

  pt_entry_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .base_i (base),
    .idx_i  (idx),
    .addr_o (mem_addr_o)
  );

  pt_entry_check #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_check (
    .level2_i   (level2),
    .write_i    (write_q),
    .pte_pn_i   (mem_rdata_i[AW-1:OFF_W]),
    .pte_perm_i (mem_rdata_i[PERM_W-1:0]),
    .fault_o    (chk_fault),
    .frame_o    (chk_frame),
    .perm_o     (chk_perm)
  );

  pt_walk_fsm #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .vaddr_i      (req_vaddr_i),
    .root_pn_i    (req_root_i[AW-1:OFF_W]),
    .write_i      (req_write_i),
    .mem_rvalid_i (mem_rvalid_i),
    .rdata_pn_i   (mem_rdata_i[AW-1:OFF_W]),
    .chk_fault_i  (chk_fault),
    .chk_frame_i  (chk_frame),
    .chk_perm_i   (chk_perm),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .level2_o     (level2),
    .base_o       (base),
    .idx_o        (idx),
    .write_o      (write_q),
    .resp_valid_o (resp_valid_o),
    .resp_fault_o (fault),
    .resp_frame_o (resp_frame_o),
    .resp_paddr_o (resp_paddr_o),
    .resp_perm_o  (resp_perm_o)
  );

  assign resp_fault_o = fault;
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic [1:0]  nrd;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h0040_2ABC, 1'b0, 2'd0, 32'hABCD_EABC, 3'd7, 2'd2},
    '{32'h0040_2ABC, 1'b1, 2'd0, 32'hABCD_EABC, 3'd7, 2'd2},
    '{32'h0040_3123, 1'b0, 2'd0, 32'h1234_5123, 3'd3, 2'd2},
    '{32'h0040_3123, 1'b1, 2'd2, 32'h0000_0000, 3'd3, 2'd2},
    '{32'hFFFF_FFFF, 1'b0, 2'd0, 32'hFFFF_FFFF, 3'd7, 2'd2},
    '{32'hFFC0_0010, 1'b0, 2'd1, 32'h0000_0000, 3'd0, 2'd2},
    '{32'h0080_0000, 1'b1, 2'd1, 32'h0000_0000, 3'd0, 2'd1},
    '{32'h0000_0FFF, 1'b0, 2'd1, 32'h0000_0000, 3'd0, 2'd1},
    '{32'h0040_4777, 1'b1, 2'd0, 32'h5555_5777, 3'd5, 2'd2}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_vaddr_i = '0, req_root_i = '0;
  logic        req_ready_o, mem_req_o, mem_rvalid_i, resp_valid_o;
  logic [31:0] mem_addr_o, mem_rdata_i, resp_paddr_o;
  logic [1:0]  resp_fault_o;
  logic [19:0] resp_frame_o;
  logic [2:0]  resp_perm_o;

  pt_walker uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  int lat = 1;
  int n_seen = 0;
  logic [31:0] seen_addr [4];
  logic [31:0] mem [logic [31:0]];
  logic [1:0]  r_flt;
  logic [19:0] r_frame;
  logic [31:0] r_pa;
  logic [2:0]  r_perm;
  int          r_cyc;
  logic        r_busy, r_after_v, r_after_rdy;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: answers lat cycles after each request pulse
  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    forever begin
      @(negedge clk_i);
      if (mem_req_o === 1'b1) begin
        logic [31:0] a;
        a = mem_addr_o;
        if (n_seen < 4) seen_addr[n_seen] = a;
        n_seen++;
        repeat (lat) @(posedge clk_i);
        #1 mem_rvalid_i = 1'b1; mem_rdata_i = rd(a);
        @(posedge clk_i);
        #1 mem_rvalid_i = 1'b0; mem_rdata_i = '0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input logic wr,
                      input int l, input bit hold);
    lat = l;
    n_seen = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_root_i = root; req_write_i = wr;
    @(negedge clk_i);
    r_cyc = 1;
    r_busy = req_ready_o;
    if (hold) begin
      req_vaddr_i = 32'hFFFF_FFFF; req_write_i = 1'b1;
    end else req_valid_i = 1'b0;
    while (!resp_valid_o && r_cyc < 200) begin
      @(negedge clk_i);
      r_cyc++;
    end
    req_valid_i = 1'b0;
    r_flt = resp_fault_o; r_frame = resp_frame_o; r_pa = resp_paddr_o; r_perm = resp_perm_o;
    @(negedge clk_i);
    r_after_v = resp_valid_o;
    r_after_rdy = req_ready_o;
  endtask

  task automatic run_vec(input vec_t v, input logic [31:0] root, input int l, input bit hold);
    string t;
    logic [31:0] a1, a2;
    int exp_cyc;
    t = (v.flt == 2'd1) ? ((v.nrd == 2'd1) ? "R4" : "R5") : (v.flt == 2'd2) ? "R6" : "R2";
    walk(v.va, root, v.wr, l, hold);
    a1 = {root[31:12], 12'h000} + {20'h0, v.va[31:22], 2'b00};
    a2 = {rd(a1) & 32'hFFFF_F000} + {20'h0, v.va[21:12], 2'b00};
    exp_cyc = (v.nrd == 2'd2) ? 3 + 2*l : 2 + l;
    chk({t, " fault"}, {30'h0, r_flt}, {30'h0, v.flt});
    chk({t, " frame"}, {12'h0, r_frame}, (v.flt == 2'd0) ? {12'h0, v.pa[31:12]} : 32'h0);
    chk({t, " paddr"}, r_pa, v.pa);
    chk("R3 perm", {29'h0, r_perm}, {29'h0, v.perm});
    chk("R9 reads", n_seen, {30'h0, v.nrd});
    chk("R1 addr1", seen_addr[0], a1);
    if (v.nrd == 2'd2) chk("R1 addr2", seen_addr[1], a2);
    chk("R8 latency", r_cyc, exp_cyc);
    chk("R7 busy", {31'h0, r_busy}, 32'h0);
    chk("R8 pulse", {31'h0, r_after_v}, 32'h0);
    chk("R8 ready", {31'h0, r_after_rdy}, 32'h1);
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0001_0FFC] = 32'h0003_0001;
    mem[32'h0001_0008] = 32'h0004_0006;
    mem[32'h0002_0008] = 32'hABCD_E007;
    mem[32'h0002_000C] = 32'h1234_5003;
    mem[32'h0002_0010] = 32'h5555_5005;
    mem[32'h0003_0FFC] = 32'hFFFF_F007;
    mem[32'h0003_0000] = 32'h0000_0006;

    // R10: state during and after reset
    #(CLK_PERIOD * 2 + 2);
    chk("R10 rdy in rst", {31'h0, req_ready_o}, 32'h1);
    chk("R10 req in rst", {31'h0, mem_req_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 ready", {31'h0, req_ready_o}, 32'h1);
    chk("R10 resp", {31'h0, resp_valid_o}, 32'h0);
    chk("R10 mem_req", {31'h0, mem_req_o}, 32'h0);

    foreach (VEC[i]) run_vec(VEC[i], ROOT, 1, 1'b0);

    // R1: root low bits ignored, slower memory
    run_vec(VEC[0], ROOT | 32'h0000_0FFF, 3, 1'b0);
    // R7: request held during walk is ignored
    run_vec(VEC[2], ROOT, 2, 1'b1);
    repeat (3) begin
      @(negedge clk_i);
      chk("R7 no new walk", {31'h0, mem_req_o}, 32'h0);
    end
    run_vec(VEC[6], ROOT, 3, 1'b0);

    // R10: reset mid-walk abandons it
    lat = 2;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = VEC[0].va; req_root_i = ROOT; req_write_i = 1'b0;
    @(negedge clk_i); req_valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 mid rdy", {31'h0, req_ready_o}, 32'h1);
    rst_ni = 1'b1;
    repeat (6) begin
      @(negedge clk_i);
      chk("R10 no resp", {31'h0, resp_valid_o}, 32'h0);
    end
    run_vec(VEC[4], ROOT, 1, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule